// File: doc/BRIEF.md
# Display wraparound address adjuster

This block folds a running display fetch address back into a display area that sits at the top of a 32K memory. A video address counter supplies four mid-order address bits (worth 2K each) and an overflow flag that rises once the count has run past the 32K boundary. On overflow the block subtracts the size of the current display area, so the fetch restarts at the bottom of that area. Without overflow the four bits pass through unchanged.

The display size is picked by a 2-bit size code held in two cells of a small bit-addressable latch. Software writes one cell at a time by giving a bit index, a data bit and a write strobe. A decoder turns the overflow flag and the size code into the one's complement of the size in 2K units. A fixed 4-bit adder with carry-in 1 then adds that operand, so it subtracts the size modulo 16.

Top module: `disp_wrap_adj`

## Requirements
- R1: With `ma_ovf` = 0, `adj_addr` equals `ma_mid` for every size code.
- R2: With `ma_ovf` = 1 and size code 00, 8 units (16K) are subtracted: `ma_mid` = 0 gives `adj_addr` = 8 (restart at byte 0x4000).
- R3: With `ma_ovf` = 1 and size code 01, 4 units (8K) are subtracted: `ma_mid` = 0 gives 12 (restart at 0x6000).
- R4: With `ma_ovf` = 1 and size code 10, 10 units (20K) are subtracted: `ma_mid` = 0 gives 6 (restart at 0x3000).
- R5: With `ma_ovf` = 1 and size code 11, 5 units (10K) are subtracted: `ma_mid` = 0 gives 11 (restart at 0x5800).
- R6: The subtraction wraps modulo 16 and the carry out is dropped, so `adj_addr` equals bits 14..11 of ((ma_ovf·0x8000 + ma_mid·0x800 − size) mod 0x8000).
- R7: A clock edge with `lat_we` = 1 and `lat_idx` = 4 loads `lat_bit` into size-code bit 0; with `lat_idx` = 5 it loads size-code bit 1. The new code acts on `adj_addr` after that edge.
- R8: A write to any other index, or any edge with `lat_we` = 0, leaves the size code unchanged.
- R9: While `rst_n` is low the size code is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the size-code latch |
| rst_n | input | 1 | Asynchronous active-low reset |
| ma_mid | input | 4 | Fetch address bits worth 2K each |
| ma_ovf | input | 1 | Fetch address has passed the 32K top |
| lat_we | input | 1 | Latch write strobe |
| lat_idx | input | 3 | Latch cell index |
| lat_bit | input | 1 | Data bit for the addressed cell |
| adj_addr | output | 4 | Adjusted address bits |

## Verification
The bench builds the block with its default parameters: a 4-bit address slice, a 3-bit latch index, size-code cells at indices 4 and 5, and unit sizes 8, 4, 10 and 5. With these values the whole input space of 2 overflow states, 4 size codes and 16 address values is small enough to sweep fully. Each point is checked against a byte-address model that subtracts the area size modulo 32K. Directed steps then cover the reset code, writes to unused latch cells and writes with the strobe low.

// File: rtl/disp_wrap_pkg.sv
package disp_wrap_pkg;
    localparam int AA_W_DEF   = 4;
    localparam int IDX_W_DEF  = 3;
    localparam int CODE_W     = 2;
    localparam int N_SIZES    = 1 << CODE_W;

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } szlat_t;
endpackage

// File: rtl/wrap_size_latch.sv
module wrap_size_latch
    import disp_wrap_pkg::*;
#(
    parameter int IDX_W  = IDX_W_DEF,
    parameter int LO_BIT = 4,
    parameter int HI_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wbit,
    output logic [CODE_W-1:0] code
);
    localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(LO_BIT);
    localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(HI_BIT);

    szlat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && idx == LO_IDX) st_d.code[0] = wbit;
        if (we && idx == HI_IDX) st_d.code[1] = wbit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code = st_q.code;

    // R7: addressed cells take the data bit
    p_load_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == LO_IDX) |=> (code[0] == $past(wbit)));
    p_load_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == HI_IDX) |=> (code[1] == $past(wbit)));
    // R8: other writes leave the code alone
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && (idx == LO_IDX || idx == HI_IDX)) |=> $stable(code));
    // R9: code is cleared by reset
    p_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (code == '0));
endmodule

// File: rtl/wrap_decoder.sv
module wrap_decoder
    import disp_wrap_pkg::*;
#(
    parameter int AA_W = AA_W_DEF,
    parameter logic [N_SIZES*AA_W-1:0] UNITS = '0
) (
    input  logic              ovf,
    input  logic [CODE_W-1:0] code,
    output logic [AA_W-1:0]   opnd
);
    logic [AA_W-1:0] inv_units [N_SIZES];

    for (genvar k = 0; k < N_SIZES; k++) begin : g_inv
        assign inv_units[k] = ~UNITS[k*AA_W +: AA_W];
    end

    always_comb begin
        if (ovf) opnd = inv_units[code];
        else     opnd = '1;
    end
endmodule

// File: rtl/wrap_adder.sv
module wrap_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [W-1:0] carry;

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = a[i] ^ b[i] ^ carry[i];
        if (i < W-1) begin : g_carry
            assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
        end
    end
endmodule

// File: rtl/disp_wrap_adj.sv
module disp_wrap_adj
    import disp_wrap_pkg::*;
#(
    parameter int AA_W   = AA_W_DEF,
    parameter int IDX_W  = IDX_W_DEF,
    parameter int LO_BIT = 4,
    parameter int HI_BIT = 5,
    parameter logic [N_SIZES*AA_W-1:0] SIZE_UNITS =
        {AA_W'(5), AA_W'(10), AA_W'(4), AA_W'(8)}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AA_W-1:0]  ma_mid,
    input  logic             ma_ovf,
    input  logic             lat_we,
    input  logic [IDX_W-1:0] lat_idx,
    input  logic             lat_bit,
    output logic [AA_W-1:0]  adj_addr
);
    logic [CODE_W-1:0] size_code;
    logic [AA_W-1:0]   sub_opnd;

    wrap_size_latch #(.IDX_W(IDX_W), .LO_BIT(LO_BIT), .HI_BIT(HI_BIT)) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (lat_we),
        .idx  (lat_idx),
        .wbit (lat_bit),
        .code (size_code)
    );

    wrap_decoder #(.AA_W(AA_W), .UNITS(SIZE_UNITS)) u_dec (
        .ovf (ma_ovf),
        .code(size_code),
        .opnd(sub_opnd)
    );

    wrap_adder #(.W(AA_W)) u_add (
        .a  (ma_mid),
        .b  (sub_opnd),
        .sum(adj_addr)
    );

    localparam logic [AA_W-1:0] START0 = AA_W'(0) - SIZE_UNITS[0*AA_W +: AA_W];
    localparam logic [AA_W-1:0] START1 = AA_W'(0) - SIZE_UNITS[1*AA_W +: AA_W];
    localparam logic [AA_W-1:0] START2 = AA_W'(0) - SIZE_UNITS[2*AA_W +: AA_W];
    localparam logic [AA_W-1:0] START3 = AA_W'(0) - SIZE_UNITS[3*AA_W +: AA_W];

    // R1: no overflow, no change
    p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ma_ovf |-> (adj_addr == ma_mid));
    // R2..R5: first address after the wrap lands on the area start
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ma_ovf && size_code == 2'b00 && ma_mid == '0) |-> (adj_addr == START0));
    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ma_ovf && size_code == 2'b01 && ma_mid == '0) |-> (adj_addr == START1));
    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ma_ovf && size_code == 2'b10 && ma_mid == '0) |-> (adj_addr == START2));
    p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ma_ovf && size_code == 2'b11 && ma_mid == '0) |-> (adj_addr == START3));
    // R6: top slice minus one unit step stays one below the start of the next slice
    p_mod_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ma_ovf && ma_mid == '1) |-> (adj_addr == AA_W'(ma_mid + sub_opnd + 1'b1)));
endmodule

// File: tb/test_disp_wrap_adj.sv
module test_disp_wrap_adj;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ma_mid = '0;
    logic       ma_ovf = 1'b0;
    logic       lat_we = 1'b0;
    logic [2:0] lat_idx = '0;
    logic       lat_bit = 1'b0;
    logic [3:0] adj_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    disp_wrap_adj i_disp_wrap_adj (
        .clk(clk), .rst_n(rst_n), .ma_mid(ma_mid), .ma_ovf(ma_ovf),
        .lat_we(lat_we), .lat_idx(lat_idx), .lat_bit(lat_bit),
        .adj_addr(adj_addr)
    );

    // fields: code[10:9] ovf[8] ma[7:4] expected[3:0]
    localparam logic [10:0] VEC [8] = '{
        {2'b00, 1'b0, 4'd5,  4'd5},   // R1
        {2'b11, 1'b0, 4'd15, 4'd15},  // R1
        {2'b00, 1'b1, 4'd0,  4'd8},   // R2
        {2'b01, 1'b1, 4'd0,  4'd12},  // R3
        {2'b10, 1'b1, 4'd0,  4'd6},   // R4
        {2'b11, 1'b1, 4'd0,  4'd11},  // R5
        {2'b10, 1'b1, 4'd3,  4'd9},   // R6
        {2'b01, 1'b1, 4'd15, 4'd11}   // R6
    };

    function automatic logic [3:0] model(input logic [1:0] code, input logic ovf,
                                         input logic [3:0] ma);
        int unsigned sz;
        int unsigned addr;
        case (code)
            2'b00:   sz = 32'h4000;
            2'b01:   sz = 32'h2000;
            2'b10:   sz = 32'h5000;
            default: sz = 32'h2800;
        endcase
        addr = (ovf ? 32'h8000 : 32'h0) + ma * 32'h800;
        if (ovf) addr = addr - sz;
        addr = addr & 32'h7FFF;
        return addr[14:11];
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: adj_addr=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic b, input logic en);
        @(negedge clk);
        lat_we = en; lat_idx = idx; lat_bit = b;
        @(negedge clk);
        lat_we = 1'b0;
    endtask

    task automatic set_code(input logic [1:0] c);
        wr(3'd4, c[0], 1'b1);   // R7 bit 0 at index 4
        wr(3'd5, c[1], 1'b1);   // R7 bit 1 at index 5
    endtask

    task automatic probe(input logic ovf, input logic [3:0] ma);
        @(negedge clk);
        ma_ovf = ovf; ma_mid = ma;
        #2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        probe(1'b1, 4'd0);
        check("R9 reset code", adj_addr, 4'd8);
        rst_n = 1'b1;
        probe(1'b1, 4'd0);
        check("R9 after reset", adj_addr, 4'd8);

        for (int v = 0; v < 8; v++) begin
            set_code(VEC[v][10:9]);
            probe(VEC[v][8], VEC[v][7:4]);
            check("R1-table R2 R3 R4 R5 R6 vec", adj_addr, VEC[v][3:0]);
        end

        for (int c = 0; c < 4; c++) begin
            set_code(2'(c));
            for (int o = 0; o < 2; o++) begin
                for (int m = 0; m < 16; m++) begin
                    probe(1'(o), 4'(m));
                    check(o == 0 ? "R1 sweep" : "R6 sweep", adj_addr,
                          model(2'(c), 1'(o), 4'(m)));
                end
            end
        end

        // R7: single-bit update visible after the edge
        set_code(2'b00);
        wr(3'd5, 1'b1, 1'b1);
        probe(1'b1, 4'd0);
        check("R7 hi cell", adj_addr, 4'd6);
        wr(3'd4, 1'b1, 1'b1);
        probe(1'b1, 4'd0);
        check("R7 lo cell", adj_addr, 4'd11);

        // R8: other cells and strobe low leave code 11
        wr(3'd3, 1'b0, 1'b1);
        probe(1'b1, 4'd0);
        check("R8 index 3", adj_addr, 4'd11);
        wr(3'd6, 1'b0, 1'b1);
        probe(1'b1, 4'd0);
        check("R8 index 6", adj_addr, 4'd11);
        wr(3'd4, 1'b0, 1'b0);
        wr(3'd5, 1'b0, 1'b0);
        probe(1'b1, 4'd0);
        check("R8 strobe low", adj_addr, 4'd11);

        // R9: reset again clears code
        @(negedge clk);
        rst_n = 1'b0;
        probe(1'b1, 4'd0);
        check("R9 re-reset", adj_addr, 4'd8);
        rst_n = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #200_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule